// File: doc/BRIEF.md
# Streaming Top-Three and Mean Statistics Unit

This block takes a burst of unsigned samples, one per clock, and reduces it to four results: the arithmetic mean and the three largest sample values in descending order. A single-cycle start pulse comes with the first sample. The remaining samples follow on the next consecutive cycles until the burst length, a power of two, has been taken in. The mean is the accumulated total shifted right by the log2 of the burst length, so no divider is needed.

A two-bit selector chooses which of the four results drives the registered output. A ready flag rises once the results are final. It stays high until the next start pulse. That pulse clears every statistic before the next burst is reduced.

Top module: `rank_stats`

## Requirements
- R1: While reset is high and on the cycles after it, `ready` is 0 and `result` reads 0 for every `sel` value.
- R2: A `start` pulse taken while idle or finished marks `sample` on that cycle as the first of `2**CNT_W` samples on consecutive cycles. `ready` rises exactly `2**CNT_W` rising edges after the edge that took the start pulse.
- R3: Every sample is added to a total that is `DATA_W+CNT_W` bits wide, so it cannot wrap. With `sel` = 00, `result` shows that total shifted right by `CNT_W` bits, which is the floor of the mean.
- R4: The three largest samples are kept in ranked order. A sample strictly above the largest shifts the old first and second places down one place. A sample above only the second place shifts the old second down to third. A sample above only the third place replaces it. Equal values therefore occupy several places.
- R5: With `sel` = 01 `result` shows the largest sample, with 10 the second largest, and with 11 the third largest. With fewer than three nonzero samples, the remaining places read 0.
- R6: `result` is registered. It reflects `sel` and the statistics one clock edge after `sel` is applied.
- R7: After `ready` rises, the results and `ready` hold steady until the next `start`. `ready` falls at the edge that takes that pulse.
- R8: A new burst starts from cleared statistics. Smaller values in a later burst give smaller results.
- R9: A `start` pulse during a burst is ignored. The burst keeps its length, and that cycle's `sample` is counted as an ordinary sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse qualifying the first sample of a burst |
| sample | input | DATA_W | Unsigned sample, one per cycle during a burst |
| sel | input | 2 | Result selector: 00 mean, 01 first, 10 second, 11 third |
| result | output | DATA_W | Registered selected result |
| ready | output | 1 | High while the results of the last burst are final |

## Verification
Random bursts with wide values test the ranking against a bench model of insertion with a shift, and also the floor of the mean. A strictly ascending burst forces a shift of all three places on every sample, while a descending burst fills each place once and never shifts. A burst with repeated maxima shows that equal values fill several places. An all-zero burst and one with a single nonzero value leave the lower places at zero. A second burst of smaller values after a large one shows that the statistics are cleared. A start pulse in mid-burst must change neither the timing nor the results.

// File: rtl/rank_stats_pkg.sv
package rank_stats_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_SETTL = 2'd2,
    ST_DONE  = 2'd3
  } rs_state_e;

  localparam logic [1:0] SEL_MEAN   = 2'b00;
  localparam logic [1:0] SEL_FIRST  = 2'b01;
  localparam logic [1:0] SEL_SECOND = 2'b10;
  localparam logic [1:0] SEL_THIRD  = 2'b11;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rank_stats_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic last,
  output logic load,
  output logic take,
  output logic ready
);
  rs_state_e state_q, state_d;

  // A start pulse is honoured only outside a burst (R9).
  assign load = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign take = (state_q == ST_ACC);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (load) state_d = ST_ACC;
      ST_ACC:   if (last) state_d = ST_SETTL;
      ST_SETTL: state_d = ST_DONE;
      ST_DONE:  if (load) state_d = ST_ACC;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready   <= 1'b0;
    end else begin
      state_q <= state_d;
      ready   <= (state_d == ST_DONE);
    end
  end
endmodule

// File: rtl/rs_accum.sv
module rs_accum #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    take,
  input  logic [DATA_W-1:0]       sample,
  output logic [DATA_W+CNT_W-1:0] total,
  output logic                    last
);
  localparam int SUM_W = DATA_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] ext;

  assign ext  = {{CNT_W{1'b0}}, sample};
  assign last = take && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
      cnt_q <= '0;
    end else if (load) begin
      total <= ext;
      cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (take) begin
      total <= total + ext;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rs_ranker.sv
module rs_ranker #(
  parameter int DATA_W = 8,
  parameter int RANKS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              take,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] rank_q [RANKS]
);
  logic [DATA_W-1:0] base   [RANKS];
  logic [DATA_W-1:0] rank_d [RANKS];
  logic [RANKS-1:0]  above;

  for (genvar g = 0; g < RANKS; g++) begin : g_slot
    assign base[g]  = load ? '0 : rank_q[g];
    assign above[g] = sample > base[g];
    if (g == 0) begin : g_top
      assign rank_d[g] = above[g] ? sample : base[g];
    end else begin : g_low
      assign rank_d[g] = !above[g]   ? base[g]   :
                         above[g-1]  ? base[g-1] : sample;
    end

    always_ff @(posedge clk) begin
      if (rst)
        rank_q[g] <= '0;
      else if (load || take)
        rank_q[g] <= rank_d[g];
    end
  end
endmodule

// File: rtl/rank_stats.sv
module rank_stats
  import rank_stats_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] sample,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] result,
  output logic              ready
);
  localparam int SUM_W = DATA_W + CNT_W;
  localparam int RANKS = 3;

  logic              load, take, last;
  logic [SUM_W-1:0]  total;
  logic [DATA_W-1:0] ranks [RANKS];
  logic [DATA_W-1:0] mean;
  logic [DATA_W-1:0] pick;

  rs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .last(last),
    .load(load), .take(take), .ready(ready)
  );

  rs_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst(rst), .load(load), .take(take),
    .sample(sample), .total(total), .last(last)
  );

  rs_ranker #(.DATA_W(DATA_W), .RANKS(RANKS)) u_rank (
    .clk(clk), .rst(rst), .load(load), .take(take),
    .sample(sample), .rank_q(ranks)
  );

  assign mean = total[SUM_W-1:CNT_W];

  always_comb begin
    case (sel)
      SEL_MEAN:   pick = mean;
      SEL_FIRST:  pick = ranks[0];
      SEL_SECOND: pick = ranks[1];
      default:    pick = ranks[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= pick;
  end
endmodule

// File: rtl/rank_stats_chk.sv
module rank_stats_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic [1:0]              sel,
  input logic [DATA_W-1:0]       result,
  input logic                    ready,
  input logic [DATA_W-1:0]       r0,
  input logic [DATA_W-1:0]       r1,
  input logic [DATA_W-1:0]       r2,
  input logic [DATA_W+CNT_W-1:0] total
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ready && result == '0));

  // R4
  rank_order_chk: assert property (@(posedge clk) disable iff (rst)
    (r0 >= r1) && (r1 >= r2));

  // R4
  max_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (r0 >= $past(r0)) && (total >= $past(total)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(r0) && $stable(r1) && $stable(r2) && $stable(total)));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);

  // R6
  first_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && sel == 2'b01) |=> (result == $past(r0)));

  // R3
  mean_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && sel == 2'b00) |=> (result == $past(total[DATA_W+CNT_W-1:CNT_W])));
endmodule

bind rank_stats rank_stats_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sel(sel), .result(result),
  .ready(ready), .r0(ranks[0]), .r1(ranks[1]), .r2(ranks[2]), .total(total)
);

// File: tb/test_rank_stats.sv
module test_rank_stats;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int K  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [1:0]    sel = 2'b00;
  logic [DW-1:0] result;
  logic          ready;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] seq [K];
  int mid_go = -1;

  always #10 clk = ~clk;

  rank_stats #(.DATA_W(DW), .CNT_W(CW)) i_rank_stats (
    .clk(clk), .rst(rst), .start(start), .sample(sample),
    .sel(sel), .result(result), .ready(ready)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int exp_val(input int mode);
    int t0 = 0, t1 = 0, t2 = 0, sum = 0;
    for (int i = 0; i < K; i++) begin
      int v = seq[i];
      sum += v;
      if (v > t0) begin t2 = t1; t1 = t0; t0 = v; end
      else if (v > t1) begin t2 = t1; t1 = v; end
      else if (v > t2) t2 = v;
    end
    case (mode)
      0: return sum / K;
      1: return t0;
      2: return t1;
      default: return t2;
    endcase
  endfunction

  task automatic run_burst(input string tag);
    @(negedge clk);
    start  = 1'b1;
    sample = seq[0];
    for (int i = 1; i < K; i++) begin
      @(negedge clk);
      start  = (i == mid_go);
      sample = seq[i];
      if (i == 1) check({tag, " R7 ready low after start"}, ready, 0);
    end
    @(negedge clk);
    start  = 1'b0;
    sample = '0;
    check({tag, " R2 ready not yet"}, ready, 0);
    @(negedge clk);
    check({tag, " R2 ready rises"}, ready, 1);
    for (int m = 0; m < 4; m++) begin
      sel = m[1:0];
      @(negedge clk);
      check($sformatf("%s %s sel=%0d", tag, (m == 0) ? "R3" : "R5", m), result, exp_val(m));
    end
    repeat (3) @(negedge clk);
    check({tag, " R7 ready held"}, ready, 1);
    check({tag, " R7 result held"}, result, exp_val(3));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 ready in reset", ready, 0);
    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      sel = m[1:0];
      @(negedge clk);
      check("R1 result after reset", result, 0);
      check("R1 ready after reset", ready, 0);
    end

    // ascending: full shift on every sample (R4)
    for (int i = 0; i < K; i++) seq[i] = DW'(10 + 20 * i);
    run_burst("ascending R4");
    // descending: no shifts (R4)
    for (int i = 0; i < K; i++) seq[i] = DW'(250 - 30 * i);
    run_burst("descending R4");
    // repeated maximum fills several places (R4)
    for (int i = 0; i < K; i++) seq[i] = (i % 3 == 0) ? 8'd200 : 8'd7;
    run_burst("duplicates R4");
    check("R4 duplicate second", exp_val(2), 200);
    // all zero, and one nonzero value (R5)
    for (int i = 0; i < K; i++) seq[i] = '0;
    run_burst("zeros R5");
    seq[K/2] = 8'd99;
    run_burst("single R5");
    // maximum values: total width, no wrap (R3)
    for (int i = 0; i < K; i++) seq[i] = 8'hFF;
    run_burst("full-scale R3");
    // smaller after larger: statistics cleared (R8)
    for (int i = 0; i < K; i++) seq[i] = DW'(1 + i % 4);
    run_burst("after-large R8");
    // mid-burst start ignored (R9)
    mid_go = 3;
    for (int i = 0; i < K; i++) seq[i] = DW'($urandom_range(0, 255));
    run_burst("mid-start R9");
    mid_go = -1;
    // random bursts (R3 R4 R6)
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < K; i++) seq[i] = DW'($urandom_range(0, 255));
      run_burst($sformatf("random%0d R6", r));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule